// File: doc/BRIEF.md
# Configuration Access Register Window

This block is a host-facing register window that sits between a simple register port and a configuration engine. Through eleven dword registers the host can identify the window, program a control word, stream configuration words toward the engine and pick up the words the engine returns after a configuration register read. Configuration words that the host writes are held in a 16-entry FIFO. The FIFO hands them to the engine over a valid/ready stream, but only while the window is enabled and write data is allowed.

Status shows a sticky engine error, the end-of-startup level, read completion with a word count, a sticky FIFO overflow flag and a 4-bit FIFO fill level. Every status field except the release request is hidden while the window is disabled. The two reset controls only act while the window is enabled. The module reset clears the window's own state. The engine reset is driven to the engine and clears the error flag. Two control bits pass straight through to output pins: the host access request and the design switch. The release request input passes straight into status.

Top module: `cfg_win_top`

## Requirements
- R1: After reset, the control register reads 0, status reads 0 apart from bit 24, and dword addresses 0, 1, 2 and 3 return the extended header, vendor header, device ID and bitstream version parameters. Addresses 11 and above read 0.
- R2: The control register keeps only bits 0 (enable), 1 (read enable), 4 (engine reset), 5 (module reset), 8 (host access request), 12 (design switch) and 16 (write-data enable); all other bits read 0. Each write updates only the bytes whose strobe bit is set.
- R3: The write-data register (address 6) always reads 0. A write to it while bit 16 is 0 is dropped and leaves the FIFO occupancy unchanged.
- R4: FIFO words go out on the engine stream in write order, and only while control bits 0 and 16 are both 1.
- R5: Status bits 15:12 give the FIFO occupancy modulo 16, so a full FIFO shows 0. A write into a full FIFO is lost and sets status bit 8, which stays set.
- R6: With bit 0 set, control bit 5 raises the module-reset output one cycle after the write and then clears the FIFO, the overflow flag, read complete and read count. Without bit 0 it does nothing.
- R7: Status bit 0 latches the engine error input and holds it. With bit 0 set, control bit 4 raises the engine-reset output one cycle after the write and clears the error flag.
- R8: While bit 1 is set, an engine return with count 1 to 4 sets status bit 4, puts the count in bits 7:5 and loads read-data words 0 upward (addresses 7 to 10). Returns with any other count are ignored. Writing bit 1 to 0 clears read complete but keeps the count.
- R9: While control bit 0 is 0, status bits other than 24 read 0.
- R10: Control bit 8 drives the host-request output and bit 12 drives the design-select output, both registered. Status bit 24 shows the release-request input and status bit 1 shows the end-of-startup input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wen | input | 1 | Host write strobe |
| host_ren | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Dword address |
| host_wdata | input | 32 | Host write data |
| host_wstrb | input | 4 | Byte enables for writes |
| host_rdata | output | 32 | Read data, registered |
| host_rvalid | output | 1 | Read data valid, one cycle after host_ren |
| eng_wvalid | output | 1 | Configuration word valid toward engine |
| eng_wready | input | 1 | Engine accepts word |
| eng_wdata | output | 32 | Configuration word |
| eng_rd_valid | input | 1 | Engine return event |
| eng_rd_count | input | 3 | Number of returned words |
| eng_rd_data | input | 128 | Returned words, word i at bits 32i+31:32i |
| eng_err | input | 1 | Engine error indication |
| eng_eos | input | 1 | End-of-startup level |
| eng_reset | output | 1 | Engine reset, registered |
| mod_reset | output | 1 | Module reset indication, registered |
| arb_release_req | input | 1 | Release request from the other configuration user |
| arb_host_req | output | 1 | Host access request |
| design_sel | output | 1 | Design switch |

## Verification
A register read returns its data in the cycle after the strobe, so the bench samples host_rdata at the falling edge after that rising edge. Control writes take effect at the edge on which they are accepted. The reset and pass-through outputs follow one edge later. The clearing done by the module and engine resets lands one further edge after that, so the bench waits three cycles before reading status back. Stream words are recorded at falling edges when valid and ready are both high, which is exactly the set of words the following rising edge pops. This lets the bench compare order and count arithmetically against the words it wrote.

// File: rtl/cfg_win_pkg.sv
package cfg_win_pkg;
  localparam int A_EXT  = 0;
  localparam int A_VND  = 1;
  localparam int A_DEV  = 2;
  localparam int A_VER  = 3;
  localparam int A_STAT = 4;
  localparam int A_CTRL = 5;
  localparam int A_WDAT = 6;
  localparam int A_RD0  = 7;

  localparam int C_EN    = 0;
  localparam int C_RDEN  = 1;
  localparam int C_ERST  = 4;
  localparam int C_MRST  = 5;
  localparam int C_HREQ  = 8;
  localparam int C_DSEL  = 12;
  localparam int C_WDEN  = 16;

  localparam logic [31:0] CTRL_MASK = 32'h0001_1133;
endpackage

// File: rtl/cfg_win_fifo.sv
module cfg_win_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic [$clog2(DEPTH):0] count,
  output logic          ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
      if (push && full) ovf <= 1'b1;
    end
  end

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr) |=> ovf);
  // R4
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  // R6
  clr_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0 && !ovf));
endmodule

// File: rtl/cfg_win_rdcap.sv
module cfg_win_rdcap #(
  parameter int DW = 32,
  parameter int NW = 4,
  parameter int CW = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   rden,
  input  logic                   ev_valid,
  input  logic [CW-1:0]          ev_count,
  input  logic [NW*DW-1:0]       ev_data,
  output logic                   cmpl,
  output logic [CW-1:0]          cnt,
  output logic [NW-1:0][DW-1:0]  words
);
  localparam logic [CW-1:0] NW_C = CW'(NW);
  logic ev_ok;
  assign ev_ok = ev_valid && rden && (ev_count != '0) && (ev_count <= NW_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpl  <= 1'b0;
      cnt   <= '0;
      words <= '0;
    end else if (clr) begin
      cmpl <= 1'b0;
      cnt  <= '0;
    end else if (!rden) begin
      cmpl <= 1'b0;
    end else if (ev_ok) begin
      cmpl <= 1'b1;
      cnt  <= ev_count;
      for (int i = 0; i < NW; i++)
        if (CW'(i) < ev_count) words[i] <= ev_data[i*DW +: DW];
    end
  end

  // R8
  rdcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cmpl |-> (cnt != '0 && cnt <= NW_C));
  // R8
  rdcmpl_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !rden |=> !cmpl);
endmodule

// File: rtl/cfg_win_top.sv
module cfg_win_top #(
  parameter int          ADDR_W     = 4,
  parameter int          FIFO_DEPTH = 16,
  parameter int          RD_WORDS   = 4,
  parameter logic [31:0] EXT_HDR    = 32'h0001_000B,
  parameter logic [31:0] VND_HDR    = 32'h02C0_0001,
  parameter logic [31:0] DEV_ID     = 32'h1234_5093,
  parameter logic [31:0] BS_VER     = 32'h0000_0A01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wen,
  input  logic              host_ren,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  input  logic [3:0]        host_wstrb,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  output logic              eng_wvalid,
  input  logic              eng_wready,
  output logic [31:0]       eng_wdata,
  input  logic              eng_rd_valid,
  input  logic [2:0]        eng_rd_count,
  input  logic [127:0]      eng_rd_data,
  input  logic              eng_err,
  input  logic              eng_eos,
  output logic              eng_reset,
  output logic              mod_reset,
  input  logic              arb_release_req,
  output logic              arb_host_req,
  output logic              design_sel
);
  import cfg_win_pkg::*;
  localparam int DW  = 32;
  localparam int FCW = $clog2(FIFO_DEPTH) + 1;

  logic [31:0]  ctrl_q;
  logic         err_q;
  logic         fifo_push, fifo_empty, fifo_ovf;
  logic [FCW-1:0] fifo_cnt;
  logic         rd_cmpl;
  logic [2:0]   rd_cnt;
  logic [RD_WORDS-1:0][DW-1:0] rd_words;
  logic [31:0]  status, rd_mux;
  logic         en, wden;

  assign en   = ctrl_q[C_EN];
  assign wden = ctrl_q[C_WDEN];

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (host_wen && host_addr == ADDR_W'(A_CTRL))
      for (int b = 0; b < 4; b++)
        if (host_wstrb[b]) ctrl_q[8*b +: 8] <= host_wdata[8*b +: 8] & CTRL_MASK[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_reset    <= 1'b0;
      mod_reset    <= 1'b0;
      arb_host_req <= 1'b0;
      design_sel   <= 1'b0;
    end else begin
      eng_reset    <= en && ctrl_q[C_ERST];
      mod_reset    <= en && ctrl_q[C_MRST];
      arb_host_req <= ctrl_q[C_HREQ];
      design_sel   <= ctrl_q[C_DSEL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || eng_reset) err_q <= 1'b0;
    else if (eng_err)     err_q <= 1'b1;
  end

  assign fifo_push  = host_wen && host_addr == ADDR_W'(A_WDAT) && wden;
  assign eng_wvalid = en && wden && !fifo_empty;

  cfg_win_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(mod_reset),
    .push(fifo_push), .wdata(host_wdata),
    .pop(eng_wvalid && eng_wready), .rdata(eng_wdata),
    .empty(fifo_empty), .count(fifo_cnt), .ovf(fifo_ovf)
  );

  cfg_win_rdcap #(.DW(DW), .NW(RD_WORDS), .CW(3)) u_rdcap (
    .clk(clk), .rst(rst), .clr(mod_reset), .rden(ctrl_q[C_RDEN]),
    .ev_valid(eng_rd_valid), .ev_count(eng_rd_count),
    .ev_data(eng_rd_data[RD_WORDS*DW-1:0]),
    .cmpl(rd_cmpl), .cnt(rd_cnt), .words(rd_words)
  );

  always_comb begin
    status     = '0;
    status[24] = arb_release_req;
    if (en) begin
      status[0]     = err_q;
      status[1]     = eng_eos;
      status[4]     = rd_cmpl;
      status[7:5]   = rd_cnt;
      status[8]     = fifo_ovf;
      status[15:12] = fifo_cnt[3:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (int'(host_addr))
      A_EXT:  rd_mux = EXT_HDR;
      A_VND:  rd_mux = VND_HDR;
      A_DEV:  rd_mux = DEV_ID;
      A_VER:  rd_mux = BS_VER;
      A_STAT: rd_mux = status;
      A_CTRL: rd_mux = ctrl_q;
      default: rd_mux = '0;
    endcase
    for (int i = 0; i < RD_WORDS; i++)
      if (host_addr == ADDR_W'(A_RD0 + i)) rd_mux = rd_words[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_ren;
      if (host_ren) host_rdata <= rd_mux;
    end
  end

  // R7
  eng_rst_clears_err_chk: assert property (@(posedge clk) disable iff (rst)
    eng_reset |=> !err_q);
  // R6
  mod_rst_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_reset) |-> $past(en));
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q && !eng_reset) |=> err_q);
endmodule

// File: tb/cfg_win_top_bench.sv
module cfg_win_top_bench;
  logic clk = 0, rst = 1;
  logic host_wen = 0, host_ren = 0;
  logic [3:0] host_addr = 0;
  logic [31:0] host_wdata = 0;
  logic [3:0] host_wstrb = 0;
  logic [31:0] host_rdata;
  logic host_rvalid, eng_wvalid, eng_wready = 0;
  logic [31:0] eng_wdata;
  logic eng_rd_valid = 0;
  logic [2:0] eng_rd_count = 0;
  logic [127:0] eng_rd_data = 0;
  logic eng_err = 0, eng_eos = 0, eng_reset, mod_reset;
  logic arb_release_req = 0, arb_host_req, design_sel;

  int checks = 0, errors = 0;
  logic [31:0] cap [64];
  int cap_n = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  cfg_win_top u_cfg_win_top (.*);

  always @(negedge clk)
    if (!rst && eng_wvalid && eng_wready && cap_n < 64) begin
      cap[cap_n] = eng_wdata;
      cap_n++;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    @(negedge clk);
    host_wen = 1; host_addr = 4'(a); host_wdata = d; host_wstrb = s;
    @(negedge clk);
    host_wen = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    host_ren = 1; host_addr = 4'(a);
    @(negedge clk);
    host_ren = 0;
    d = host_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_event(input logic [2:0] n, input logic [127:0] d);
    @(negedge clk);
    eng_rd_valid = 1; eng_rd_count = n; eng_rd_data = d;
    @(negedge clk);
    eng_rd_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state and ID registers
    rd(5, rv); chk("R1 ctrl", rv, 0);
    rd(4, rv); chk("R1 status", rv, 0);
    rd(0, rv); chk("R1 ext", rv, 32'h0001_000B);
    rd(1, rv); chk("R1 vnd", rv, 32'h02C0_0001);
    rd(2, rv); chk("R1 dev", rv, 32'h1234_5093);
    rd(3, rv); chk("R1 ver", rv, 32'h0000_0A01);
    for (int a = 11; a < 16; a++) begin rd(a, rv); chk("R1 unmapped", rv, 0); end
    rd(6, rv); chk("R3 wdata reads 0", rv, 0);

    // R2 writable bits, R10 pass-through
    wr(5, 32'hFFFF_FFFF);
    wait_cyc(1);
    chk("R10 host req", {31'b0, arb_host_req}, 1);
    chk("R10 design sel", {31'b0, design_sel}, 1);
    chk("R7 eng reset out", {31'b0, eng_reset}, 1);
    chk("R6 mod reset out", {31'b0, mod_reset}, 1);
    rd(5, rv); chk("R2 mask", rv, 32'h0001_1133);
    wr(5, 0);
    wr(5, 32'h0001_0101, 4'b0001);
    rd(5, rv); chk("R2 strobe", rv, 32'h0000_0001);
    wait_cyc(1);
    chk("R10 host req off", {31'b0, arb_host_req}, 0);

    // R3 writes dropped while write-data enable low
    for (int i = 0; i < 3; i++) wr(6, 32'hDEAD_0000 + i);
    rd(4, rv); chk("R3 dropped", rv, 0);

    // R5 occupancy count
    wr(5, 32'h0001_0001);
    for (int i = 0; i < 5; i++) wr(6, 32'hA500_0000 + i);
    rd(4, rv); chk("R5 occ 5", rv, 32'h0000_5000);
    chk("R4 valid", {31'b0, eng_wvalid}, 1);

    // R4 no drain without enable; R9 masking
    wr(5, 32'h0001_0000);
    eng_wready = 1;
    wait_cyc(4);
    chk("R4 no valid", {31'b0, eng_wvalid}, 0);
    rd(4, rv); chk("R9 masked", rv, 0);
    eng_wready = 0;
    wr(5, 32'h0000_0001);
    eng_wready = 1;
    wait_cyc(4);
    eng_wready = 0;
    chk("R4 no drain w/o wden", cap_n, 0);
    wr(5, 32'h0001_0001);
    rd(4, rv); chk("R4 occ kept", rv, 32'h0000_5000);
    eng_wready = 1;
    wait_cyc(8);
    eng_wready = 0;
    chk("R4 drained count", cap_n, 5);
    for (int i = 0; i < 5; i++) chk("R4 order", cap[i], 32'hA500_0000 + i);
    rd(4, rv); chk("R4 empty", rv, 0);

    // R5 full and overflow
    for (int i = 0; i < 17; i++) wr(6, 32'hB000_0000 + i);
    rd(4, rv); chk("R5 full overflow", rv, 32'h0000_0100);
    // R6 module reset without enable does nothing
    wr(5, 32'h0001_0020);
    wait_cyc(3);
    chk("R6 no mod reset", {31'b0, mod_reset}, 0);
    wr(5, 32'h0001_0001);
    rd(4, rv); chk("R6 kept", rv, 32'h0000_0100);
    wr(5, 32'h0001_0021);
    wait_cyc(3);
    wr(5, 32'h0001_0001);
    rd(4, rv); chk("R6 cleared", rv, 0);
    eng_wready = 1; wait_cyc(3); eng_wready = 0;
    chk("R6 fifo emptied", cap_n, 5);

    // R7 error sticky and engine reset
    @(negedge clk); eng_err = 1; @(negedge clk); eng_err = 0;
    eng_eos = 1;
    rd(4, rv); chk("R7 err sticky", rv, 32'h0000_0003);
    wr(5, 32'h0000_0010);
    wait_cyc(3);
    chk("R7 no reset w/o en", {31'b0, eng_reset}, 0);
    wr(5, 32'h0000_0011);
    wait_cyc(3);
    wr(5, 32'h0000_0001);
    rd(4, rv); chk("R7 err cleared", rv, 32'h0000_0002);
    eng_eos = 0;
    arb_release_req = 1;
    wr(5, 0);
    rd(4, rv); chk("R10 release", rv, 32'h0100_0000);
    arb_release_req = 0;

    // R8 read return
    wr(5, 32'h0000_0003);
    rd_event(3, {32'hD4, 32'hC3, 32'hB2, 32'hA1});
    rd(4, rv); chk("R8 cmpl cnt3", rv, 32'h0000_0070);
    rd(7, rv); chk("R8 rd0", rv, 32'hA1);
    rd(9, rv); chk("R8 rd2", rv, 32'hC3);
    rd(10, rv); chk("R8 rd3 untouched", rv, 0);
    rd_event(5, {32'h1, 32'h2, 32'h3, 32'h4});
    rd(4, rv); chk("R8 bad count ignored", rv, 32'h0000_0070);
    rd(7, rv); chk("R8 rd0 kept", rv, 32'hA1);
    wr(5, 32'h0000_0001);
    rd(4, rv); chk("R8 cmpl cleared", rv, 32'h0000_0060);
    rd_event(4, {32'hE4, 32'hE3, 32'hE2, 32'hE1});
    rd(4, rv); chk("R8 ignored w/o rden", rv, 32'h0000_0060);
    wr(5, 32'h0000_0003);
    rd_event(4, {32'hE4, 32'hE3, 32'hE2, 32'hE1});
    rd(4, rv); chk("R8 cnt4", rv, 32'h0000_0090);
    rd(10, rv); chk("R8 rd3", rv, 32'hE4);
    rd(6, rv); chk("R3 wdata still 0", rv, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule